// File: doc/BRIEF.md
# Completion Interrupt and Linking Unit

This block sits beside a transfer engine and decides what a transfer leaves behind once it has been handed to the engine or has finished moving data. Each channel owns one descriptor, held in a small table of parameter sets. That table also holds spare sets that serve only as reload sources. The unit reads the descriptor's option word and picks a 6-bit completion code from it. The code selects one of 64 positions. At that position the unit can latch an interrupt-pending bit, emit a one-cycle chain-event pulse, or do both. Separate enables govern the intermediate point (hand-off to the engine) and the final point (data finished). An early-completion flag moves the final point forward to hand-off time.

When a transfer finishes and its descriptor is not marked static, the unit copies a whole parameter set over the channel's descriptor. The set is chosen by the 16-bit link field. The copy does not start anything. The channel waits for its next submission, and any re-trigger comes from outside, for example by acting on the chain pulse.

Software reaches pending, clear, enable and parameter-set words through a simple word-addressed register port with a combinational read. The interrupt line is the OR of every pending bit whose enable is also set.

Top module: `cilu_top`

## Requirements
- R1: Word map: pending bits 31..0 at address 0 and 63..32 at address 1 (read only); clear words at 2 and 3 read as zero; enable words at 4 and 5; parameter set i has its option word at 32+2i and its link word at 33+2i, where the link word reads back bits 15..0 with zero above. Other addresses read zero.
- R2: After reset, all pending, enable and parameter-set words read zero, irq is low and chain_evt is zero.
- R3: The completion code is option bits 17..12. A submission on channel c uses set c. If option bit 21 is set, the pending bit at the code position is set at that clock edge. If option bit 23 is set, chain_evt bit [code] is high for exactly the one cycle after that edge.
- R4: With option bit 11 (early) clear, a finish on channel c sets the pending bit [code] if bit 20 is set and pulses chain_evt [code] if bit 22 is set. A submission alone does neither.
- R5: With option bit 11 set, the effects of bits 20 and 22 occur at submission, and a finish produces no pending bit or chain pulse.
- R6: Writing a clear word clears the pending bits where the written data has a 1 and leaves every other pending bit unchanged.
- R7: If a pending bit is set in the same cycle as a clear write with a 1 at that position, the bit ends up set.
- R8: irq is high exactly when some pending bit has its enable bit set.
- R9: On a finish on channel c with option bit 3 (static) at 0, set c is overwritten with the option and link words of set k, where k is the low log2(sets) bits of set c's link field (higher link bits are ignored). With bit 3 at 1, set c is unchanged.
- R10: A link reload starts nothing: it adds no pending bit or chain pulse beyond what the finishing option word calls for. The next submission on that channel acts on the reloaded option word.
- R11: A submission and a finish in the same cycle, on different channels, both take effect.
- R12: If a link reload and a software write target the same set in the same cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| sub_vld | input | 1 | Request handed to the transfer engine |
| sub_ch | input | CH_W | Channel of the submission |
| fin_vld | input | 1 | Transfer finished |
| fin_ch | input | CH_W | Channel of the finish |
| irq | output | 1 | Enabled-pending interrupt |
| chain_evt | output | 64 | One-cycle chain-event pulses by completion code |

## Verification
The bench targets the collisions. A set and a clear can land on one bit in the same cycle, and a design that lets the clear win would drop an interrupt silently. A submission and a finish can arrive together, and logic that serves only one of them would lose the other's bit. A reload and a software write can hit the same set in the same cycle, and the wrong priority would leave the software value in place. The bench also checks early mode. Reporting the final point at both submission and finish would leave a stray pending bit, and reporting it only at finish would be late. It checks that a reload does not fire the reloaded word's intermediate enables on its own, that the next submission does use the reloaded word, and that high link bits are ignored.

// File: rtl/cilu_pkg.sv
package cilu_pkg;
   localparam int CODE_W      = 6;
   localparam int PEND_BITS   = 1 << CODE_W;
   localparam int LINK_W      = 16;
   localparam int BIT_STATIC  = 3;
   localparam int BIT_EARLY   = 11;
   localparam int CODE_LSB    = 12;
   localparam int BIT_FIN_IRQ = 20;
   localparam int BIT_MID_IRQ = 21;
   localparam int BIT_FIN_CHN = 22;
   localparam int BIT_MID_CHN = 23;

   typedef logic [CODE_W-1:0] code_t;

   typedef struct packed {
      logic  mid_chn;
      logic  fin_chn;
      logic  mid_irq;
      logic  fin_irq;
      logic  early;
      logic  is_static;
      code_t code;
   } opt_fields_t;

   function automatic opt_fields_t split_opt(input logic [31:0] w);
      opt_fields_t f;
      f.mid_chn   = w[BIT_MID_CHN];
      f.fin_chn   = w[BIT_FIN_CHN];
      f.mid_irq   = w[BIT_MID_IRQ];
      f.fin_irq   = w[BIT_FIN_IRQ];
      f.early     = w[BIT_EARLY];
      f.is_static = w[BIT_STATIC];
      f.code      = w[CODE_LSB +: CODE_W];
      return f;
   endfunction
endpackage

// File: rtl/cilu_decode.sv
module cilu_decode import cilu_pkg::*; #(
   parameter bit AT_SUBMIT = 1'b1,
   parameter int NBITS     = PEND_BITS
) (
   input  logic             vld,
   input  logic [31:0]      opt,
   output logic [NBITS-1:0] irq_set,
   output logic [NBITS-1:0] chn_set
);
   opt_fields_t f;
   logic        want_irq;
   logic        want_chn;
   logic        unused_static;

   assign f             = split_opt(opt);
   assign unused_static = f.is_static;

   if (NBITS != PEND_BITS) begin : g_bad_nbits
      $error("cilu_decode: NBITS must equal 2**CODE_W");
   end

   if (AT_SUBMIT) begin : g_submit
      assign want_irq = f.mid_irq | (f.early & f.fin_irq);
      assign want_chn = f.mid_chn | (f.early & f.fin_chn);
   end else begin : g_finish
      assign want_irq = ~f.early & f.fin_irq;
      assign want_chn = ~f.early & f.fin_chn;
   end

   always_comb begin
      irq_set = '0;
      chn_set = '0;
      if (vld) begin
         irq_set[f.code] = want_irq;
         chn_set[f.code] = want_chn;
      end
   end
endmodule

// File: rtl/cilu_pend_bank.sv
module cilu_pend_bank #(
   parameter int NBITS = 64,
   localparam int NW   = NBITS / 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    clr_we,
   input  logic [NW-1:0]    ien_we,
   input  logic [31:0]      wdata,
   input  logic [NBITS-1:0] set_vec,
   output logic [NBITS-1:0] pend_q,
   output logic [NBITS-1:0] ien_q,
   output logic             irq
);
   logic [NW-1:0][31:0] pend_w;
   logic [NW-1:0][31:0] ien_w;

   if (NBITS % 32 != 0 || NW < 1) begin : g_bad_width
      $error("cilu_pend_bank: NBITS must be a multiple of 32");
   end

   for (genvar w = 0; w < NW; w++) begin : g_word
      logic [31:0] clr_mask;
      assign clr_mask = clr_we[w] ? wdata : 32'h0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_w[w] <= '0;
            ien_w[w]  <= '0;
         end else begin
            pend_w[w] <= (pend_w[w] & ~clr_mask) | set_vec[w*32 +: 32];
            if (ien_we[w]) ien_w[w] <= wdata;
         end
      end
   end

   assign pend_q = pend_w;
   assign ien_q  = ien_w;
   assign irq    = |(pend_w & ien_w);
endmodule

// File: rtl/cilu_param_store.sv
module cilu_param_store import cilu_pkg::*; #(
   parameter int NUM_SETS = 16,
   parameter int NUM_CH   = 4,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_link,
   input  logic [31:0]       wr_data,
   input  logic [CH_W-1:0]   sub_ch,
   input  logic              fin_vld,
   input  logic [CH_W-1:0]   fin_ch,
   output logic [31:0]       sub_opt,
   output logic [31:0]       fin_opt,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [31:0]       rd_opt,
   output logic [LINK_W-1:0] rd_lnk
);
   logic [31:0]       opt_q [NUM_SETS];
   logic [LINK_W-1:0] lnk_q [NUM_SETS];
   logic [NUM_SETS-1:0] reload;
   logic [IDX_W-1:0]  src_idx [NUM_SETS];

   if (IDX_W > LINK_W) begin : g_bad_sets
      $error("cilu_param_store: link field too narrow for NUM_SETS");
   end

   for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
      assign src_idx[i] = lnk_q[i][IDX_W-1:0];
      if (i < NUM_CH) begin : g_chan
         assign reload[i] = fin_vld && (fin_ch == CH_W'(i)) && !opt_q[i][BIT_STATIC];
      end else begin : g_spare
         assign reload[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SETS; i++) begin
            opt_q[i] <= '0;
            lnk_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_SETS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
               if (wr_link) lnk_q[i] <= wr_data[LINK_W-1:0];
               else         opt_q[i] <= wr_data;
            end
            if (reload[i]) begin
               opt_q[i] <= opt_q[src_idx[i]];
               lnk_q[i] <= lnk_q[src_idx[i]];
            end
         end
      end
   end

   assign sub_opt = opt_q[IDX_W'(sub_ch)];
   assign fin_opt = opt_q[IDX_W'(fin_ch)];
   assign rd_opt  = opt_q[rd_idx];
   assign rd_lnk  = lnk_q[rd_idx];
endmodule

// File: rtl/cilu_top.sv
module cilu_top import cilu_pkg::*; #(
   parameter int NUM_CH   = 4,
   parameter int NUM_SETS = 16,
   parameter int ADDR_W   = 7,
   parameter int SET_BASE = 32,
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 sub_vld,
   input  logic [CH_W-1:0]      sub_ch,
   input  logic                 fin_vld,
   input  logic [CH_W-1:0]      fin_ch,
   output logic                 irq,
   output logic [PEND_BITS-1:0] chain_evt
);
   localparam int NW      = PEND_BITS / 32;
   localparam int IDX_W   = $clog2(NUM_SETS);
   localparam int SET_END = SET_BASE + 2 * NUM_SETS;

   if (NUM_CH < 2 || NUM_CH > NUM_SETS || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("cilu_top: NUM_CH must be a power of two in 2..NUM_SETS");
   end
   if ((1 << IDX_W) != NUM_SETS) begin : g_bad_sets
      $error("cilu_top: NUM_SETS must be a power of two");
   end
   if (SET_BASE < 3 * NW || SET_END > (1 << ADDR_W) || IDX_W + 1 > ADDR_W) begin : g_bad_map
      $error("cilu_top: address map does not fit ADDR_W");
   end

   logic [NW-1:0]        clr_we;
   logic [NW-1:0]        ien_we;
   logic                 in_sets;
   logic [ADDR_W-1:0]    set_off;
   logic [IDX_W-1:0]     set_idx;
   logic                 set_link;
   logic                 unused_off;
   logic [31:0]          sub_opt;
   logic [31:0]          fin_opt;
   logic [31:0]          rd_opt;
   logic [LINK_W-1:0]    rd_lnk;
   logic [PEND_BITS-1:0] sub_irq, sub_chn, fin_irq, fin_chn;
   logic [PEND_BITS-1:0] pend_q;
   logic [PEND_BITS-1:0] ien_q;

   for (genvar w = 0; w < NW; w++) begin : g_strobe
      assign clr_we[w] = reg_wr && (reg_addr == ADDR_W'(NW + w));
      assign ien_we[w] = reg_wr && (reg_addr == ADDR_W'(2 * NW + w));
   end

   assign in_sets    = (32'(reg_addr) >= SET_BASE) && (32'(reg_addr) < SET_END);
   assign set_off    = reg_addr - ADDR_W'(SET_BASE);
   assign set_idx    = set_off[IDX_W:1];
   assign set_link   = set_off[0];
   assign unused_off = ^set_off;

   cilu_param_store #(.NUM_SETS(NUM_SETS), .NUM_CH(NUM_CH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && in_sets),
      .wr_idx  (set_idx),
      .wr_link (set_link),
      .wr_data (reg_wdata),
      .sub_ch  (sub_ch),
      .fin_vld (fin_vld),
      .fin_ch  (fin_ch),
      .sub_opt (sub_opt),
      .fin_opt (fin_opt),
      .rd_idx  (set_idx),
      .rd_opt  (rd_opt),
      .rd_lnk  (rd_lnk)
   );

   cilu_decode #(.AT_SUBMIT(1'b1), .NBITS(PEND_BITS)) u_dec_sub (
      .vld     (sub_vld),
      .opt     (sub_opt),
      .irq_set (sub_irq),
      .chn_set (sub_chn)
   );

   cilu_decode #(.AT_SUBMIT(1'b0), .NBITS(PEND_BITS)) u_dec_fin (
      .vld     (fin_vld),
      .opt     (fin_opt),
      .irq_set (fin_irq),
      .chn_set (fin_chn)
   );

   cilu_pend_bank #(.NBITS(PEND_BITS)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_we  (clr_we),
      .ien_we  (ien_we),
      .wdata   (reg_wdata),
      .set_vec (sub_irq | fin_irq),
      .pend_q  (pend_q),
      .ien_q   (ien_q),
      .irq     (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_evt <= '0;
      else        chain_evt <= sub_chn | fin_chn;
   end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NW; w++) begin
         if (reg_addr == ADDR_W'(w))          reg_rdata = pend_q[w*32 +: 32];
         if (reg_addr == ADDR_W'(2 * NW + w)) reg_rdata = ien_q[w*32 +: 32];
      end
      if (in_sets) reg_rdata = set_link ? {{(32-LINK_W){1'b0}}, rd_lnk} : rd_opt;
   end
endmodule

// File: rtl/cilu_chk.sv
module cilu_chk #(
   parameter int ADDR_W = 7,
   parameter int NW     = 2,
   localparam int NB    = NW * 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              sub_vld,
   input logic              fin_vld,
   input logic              irq,
   input logic [NB-1:0]     chain_evt,
   input logic [NB-1:0]     pend_q,
   input logic [NB-1:0]     ien_q
);
   logic clr_hit;
   assign clr_hit = reg_wr && (32'(reg_addr) >= NW) && (32'(reg_addr) < 2 * NW);

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6

   AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_vld && !fin_vld) |=> ((pend_q & ~$past(pend_q)) == '0)); // R10

   AST_CHAIN_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_vld && !fin_vld) |=> (chain_evt == '0)); // R3

   AST_CHAIN_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chain_evt) <= 2); // R11

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_q != '0)); // R8

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq); // R8
endmodule

bind cilu_top cilu_chk #(.ADDR_W(ADDR_W), .NW(NW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .sub_vld   (sub_vld),
   .fin_vld   (fin_vld),
   .irq       (irq),
   .chain_evt (chain_evt),
   .pend_q    (pend_q),
   .ien_q     (ien_q)
);

// File: tb/tb_cilu_top.sv
`timescale 1ns/1ps
module tb_cilu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sub_vld = 1'b0;
   logic [1:0]  sub_ch = '0;
   logic        fin_vld = 1'b0;
   logic [1:0]  fin_ch = '0;
   logic        irq;
   logic [63:0] chain_evt;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   cilu_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sub_vld(sub_vld),
      .sub_ch(sub_ch), .fin_vld(fin_vld), .fin_ch(fin_ch), .irq(irq),
      .chain_evt(chain_evt)
   );

   // behavioural reference model
   logic [63:0] m_pend, m_ien, m_chain, t_set, t_chn;
   logic [31:0] m_opt [16];
   logic [15:0] m_lnk [16];
   logic [31:0] t_opt [16];
   logic [15:0] t_lnk [16];
   logic [31:0] o;
   int          cd, src, idx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0; m_ien = '0; m_chain = '0;
         for (int i = 0; i < 16; i++) begin m_opt[i] = '0; m_lnk[i] = '0; end
      end else begin
         t_set = '0; t_chn = '0;
         for (int i = 0; i < 16; i++) begin t_opt[i] = m_opt[i]; t_lnk[i] = m_lnk[i]; end
         if (sub_vld) begin
            o = t_opt[sub_ch]; cd = int'(o[17:12]);
            if (o[21] || (o[11] && o[20])) t_set[cd] = 1'b1;
            if (o[23] || (o[11] && o[22])) t_chn[cd] = 1'b1;
         end
         if (fin_vld) begin
            o = t_opt[fin_ch]; cd = int'(o[17:12]);
            if (!o[11] && o[20]) t_set[cd] = 1'b1;
            if (!o[11] && o[22]) t_chn[cd] = 1'b1;
         end
         if (reg_wr) begin
            case (reg_addr)
               7'd2: m_pend[31:0]  = m_pend[31:0]  & ~reg_wdata;
               7'd3: m_pend[63:32] = m_pend[63:32] & ~reg_wdata;
               7'd4: m_ien[31:0]   = reg_wdata;
               7'd5: m_ien[63:32]  = reg_wdata;
               default: if (reg_addr >= 7'd32 && reg_addr < 7'd64) begin
                  idx = (int'(reg_addr) - 32) / 2;
                  if (reg_addr[0]) m_lnk[idx] = reg_wdata[15:0];
                  else             m_opt[idx] = reg_wdata;
               end
            endcase
         end
         m_pend = m_pend | t_set;
         if (fin_vld && !t_opt[fin_ch][3]) begin
            src = int'(t_lnk[fin_ch][3:0]);
            m_opt[fin_ch] = t_opt[src];
            m_lnk[fin_ch] = t_lnk[src];
         end
         m_chain = t_chn;
      end
   end

   function automatic logic [31:0] m_read(input logic [6:0] a);
      if (a == 7'd0) return m_pend[31:0];
      if (a == 7'd1) return m_pend[63:32];
      if (a == 7'd4) return m_ien[31:0];
      if (a == 7'd5) return m_ien[63:32];
      if (a >= 7'd32 && a < 7'd64)
         return a[0] ? {16'h0, m_lnk[(int'(a) - 32) / 2]} : m_opt[(int'(a) - 32) / 2];
      return 32'h0;
   endfunction

   function automatic logic [31:0] mkopt(input int code, input bit mi, input bit mc,
                                          input bit fi, input bit fc, input bit ea, input bit st);
      logic [31:0] w;
      w = '0;
      w[23] = mc; w[22] = fc; w[21] = mi; w[20] = fi;
      w[17:12] = code[5:0]; w[11] = ea; w[3] = st;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      chk("R8 irq vs model", irq, |(m_pend & m_ien));
      chk("R3 chain_evt vs model", chain_evt, m_chain);
      chk("R1 rdata vs model", reg_rdata, m_read(reg_addr));
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d;
      cyc();
      reg_wr = 1'b0;
   endtask

   task automatic sub(input int c);
      sub_vld = 1'b1; sub_ch = 2'(c);
      cyc();
      sub_vld = 1'b0;
   endtask

   task automatic fin(input int c);
      fin_vld = 1'b1; fin_ch = 2'(c);
      cyc();
      fin_vld = 1'b0;
   endtask

   task automatic peek(input int a, input logic [31:0] exp, input string tag);
      reg_addr = 7'(a);
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();
      // R2 reset state
      peek(0, 32'h0, "R2 pend lo"); peek(1, 32'h0, "R2 pend hi");
      peek(4, 32'h0, "R2 ien lo");  peek(33, 32'h0, "R2 set0 link");
      chk("R2 irq", irq, 0); chk("R2 chain", chain_evt, 0);

      wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);

      // R3 intermediate interrupt and chain
      wr(32, mkopt(5, 1, 0, 0, 0, 0, 1));
      sub(0);
      peek(0, 32'h20, "R3 mid irq sets bit5"); chk("R8 irq high", irq, 1);
      wr(32, mkopt(7, 0, 1, 0, 0, 0, 1));
      sub(0);
      chk("R3 chain pulse bit7", chain_evt, 64'h80);
      cyc();
      chk("R3 chain one cycle", chain_evt, 64'h0);

      // R6 full clear, R1 clear word reads zero
      wr(2, 32'h20);
      peek(0, 32'h0, "R6 cleared"); peek(2, 32'h0, "R1 clear reads zero");
      chk("R8 irq low", irq, 0);

      // R4 final completion
      wr(34, mkopt(40, 0, 0, 1, 1, 0, 1));
      sub(1);
      peek(1, 32'h0, "R4 submit no final");
      fin(1);
      chk("R4 chain bit40", chain_evt, 64'h1 << 40);
      peek(1, 32'h100, "R4 final pend bit40");

      // R5 early completion
      wr(36, mkopt(3, 0, 0, 1, 0, 1, 1));
      sub(2);
      peek(0, 32'h8, "R5 early at submit");
      wr(2, 32'h8);
      fin(2);
      peek(0, 32'h0, "R5 finish silent");

      // R7 set beats clear
      wr(32, mkopt(5, 1, 0, 0, 0, 0, 1));
      sub_vld = 1'b1; sub_ch = 2'd0;
      reg_wr = 1'b1; reg_addr = 7'd2; reg_wdata = 32'h20;
      cyc();
      sub_vld = 1'b0; reg_wr = 1'b0;
      peek(0, 32'h20, "R7 set wins");

      // R6 partial clear
      sub(2);
      peek(0, 32'h28, "R6 two bits");
      wr(2, 32'h8);
      peek(0, 32'h20, "R6 partial clear");

      // R8 masking
      wr(4, 32'h0);
      chk("R8 hi still enabled", irq, 1);
      wr(3, 32'h100);
      chk("R8 masked", irq, 0);
      wr(4, 32'h20);
      chk("R8 unmasked", irq, 1);
      wr(4, 32'hFFFF_FFFF);
      wr(2, 32'hFFFF_FFFF);

      // R9 link reload, R10 no trigger
      wr(48, mkopt(9, 1, 0, 0, 0, 0, 1)); wr(49, 32'h3);
      wr(38, mkopt(10, 0, 0, 1, 0, 0, 0)); wr(39, 32'h0108);
      fin(3);
      peek(0, 32'h400, "R10 only finishing word acts");
      peek(38, mkopt(9, 1, 0, 0, 0, 0, 1), "R9 option reloaded");
      peek(39, 32'h3, "R9 link reloaded");
      cyc(); cyc();
      peek(0, 32'h400, "R10 reload starts nothing");
      sub(3);
      peek(0, 32'h600, "R10 reloaded word used");

      // R9 static keeps descriptor
      fin(1);
      peek(34, mkopt(40, 0, 0, 1, 1, 0, 1), "R9 static unchanged");

      // R11 simultaneous submit and finish
      wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
      sub_vld = 1'b1; sub_ch = 2'd0; fin_vld = 1'b1; fin_ch = 2'd1;
      cyc();
      sub_vld = 1'b0; fin_vld = 1'b0;
      chk("R11 chain from finish", chain_evt, 64'h1 << 40);
      peek(0, 32'h20, "R11 submit bit"); peek(1, 32'h100, "R11 finish bit");

      // R12 reload beats software write
      wr(38, mkopt(12, 0, 0, 0, 0, 0, 0)); wr(39, 32'h8);
      fin_vld = 1'b1; fin_ch = 2'd3;
      reg_wr = 1'b1; reg_addr = 7'd38; reg_wdata = 32'hDEAD_0000;
      cyc();
      fin_vld = 1'b0; reg_wr = 1'b0;
      peek(38, mkopt(9, 1, 0, 0, 0, 0, 1), "R12 reload wins");
      peek(10, 32'h0, "R1 unmapped reads zero");
      cyc();
      finish_run();
   end
endmodule